// File: doc/BRIEF.md
# Sample-Set Capture Buffer

This block keeps complete output sample sets in a small internal store until a reader asks for them. A set is five 16-bit fields written together on one valid strobe: in-phase, quadrature, magnitude, phase and frequency. The upstream path repeats its last frequency value on every strobe, so all five fields arrive at the I/Q rate. Nothing leaves the store unless a reader requests it.

Two readers share the store. A 16-bit port reads one chosen field per access. A byte-wide processor port walks through a set one byte at a time. Both ports read the set at the shared read pointer. The store runs either as a continuous circular queue or as a one-shot capture. In capture mode an arm pulse records eight consecutive sets and then freezes the contents.

Top module: `sset_buffer`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `snap_done` is 0, and both acknowledges are 0.
- R2: A request is served only when the store is not empty. The acknowledge is high for exactly one cycle, in the cycle after the request was taken, and the read data is valid with it. A request made while the store is empty gets no acknowledge.
- R3: On the 16-bit port, `w_sel` chooses the field: 000 I, 001 Q, 010 magnitude, 011 phase, 100 frequency. A read of 100 moves the read pointer to the next set. Codes 101 to 111 return 0 and do not move the pointer.
- R4: In queue mode (`mode_snap`=0), sets come out in the order they were written. The store holds 8 sets and its pointers wrap modulo 8. `full` is 1 while 8 sets are held, and `empty` is 1 while none are held.
- R5: In queue mode, a set offered while `full` is 1 is dropped. It never appears at either read port.
- R6: Each byte-port access returns the next byte in this order: I low, I high, Q low, Q high, magnitude low, magnitude high, phase low, phase high, frequency low, frequency high. The read pointer moves after the frequency high byte.
- R7: In capture mode (`mode_snap`=1), sets offered before an arm pulse are ignored. An arm pulse empties the store, and the next 8 valid sets are recorded. Later sets are ignored.
- R8: `snap_done` rises once the eighth set of a capture is stored. It stays high until the next arm pulse, which clears it.
- R9: When both ports request in the same cycle, the 16-bit port is served. The byte port gets no acknowledge and its byte position does not move, so a held byte request is served in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_snap | input | 1 | 0 selects queue mode, 1 selects one-shot capture mode |
| arm | input | 1 | In capture mode, clears the store and starts a capture |
| wr_valid | input | 1 | A sample set is offered |
| wr_i | input | 16 | In-phase field |
| wr_q | input | 16 | Quadrature field |
| wr_mag | input | 16 | Magnitude field |
| wr_phase | input | 16 | Phase field |
| wr_freq | input | 16 | Frequency field |
| w_req | input | 1 | 16-bit port read request |
| w_sel | input | 3 | 16-bit port field select |
| w_ack | output | 1 | 16-bit port data valid |
| w_data | output | 16 | 16-bit port read data |
| b_req | input | 1 | Byte port read request |
| b_ack | output | 1 | Byte port data valid |
| b_data | output | 8 | Byte port read data |
| full | output | 1 | Store holds 8 sets |
| empty | output | 1 | Store holds no sets |
| snap_done | output | 1 | Capture of 8 sets finished |

## Verification
The hardest condition to reach is a clash between the two readers while the byte port is part-way through a set. Losing arbitration must leave the byte position where it was, and a field read on the 16-bit port must not move the pointer. The bench gets there by loading a known set and raising both requests on the same edge. It then holds only the byte request and checks that the first byte still comes out, followed by the other nine in order. Wrap-around is reached by filling the queue to the limit, offering a set that must be dropped, draining all eight sets, and writing again past slot 7.

// File: rtl/sset_pkg.sv
package sset_pkg;
  localparam int FIELD_W    = 16;
  localparam int NUM_FIELDS = 5;
  localparam int SET_W      = FIELD_W * NUM_FIELDS;
  localparam int SEL_W      = 3;
  localparam int BYTES_SET  = NUM_FIELDS * 2;
  localparam int CUR_W      = $clog2(BYTES_SET);

  typedef enum logic [SEL_W-1:0] {
    SEL_I   = 3'd0,
    SEL_Q   = 3'd1,
    SEL_MAG = 3'd2,
    SEL_PH  = 3'd3,
    SEL_FRQ = 3'd4
  } fsel_e;

  // Field at position sel inside a packed set; 0 for codes beyond the last field.
  function automatic logic [FIELD_W-1:0] pick_field(input logic [SET_W-1:0] set,
                                                    input logic [SEL_W-1:0] sel);
    if (int'(sel) < NUM_FIELDS) return set[int'(sel)*FIELD_W +: FIELD_W];
    return '0;
  endfunction

  // Byte number cur: field cur/2, low byte when cur is even.
  function automatic logic [7:0] pick_byte(input logic [SET_W-1:0] set,
                                           input logic [CUR_W-1:0] cur);
    logic [FIELD_W-1:0] f;
    f = pick_field(set, SEL_W'(cur >> 1));
    return cur[0] ? f[15:8] : f[7:0];
  endfunction
endpackage

// File: rtl/sset_mem.sv
module sset_mem
  import sset_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [SET_W-1:0] wr_set,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [SET_W-1:0] rd_set
);
  logic [SET_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_set;
  end

  assign rd_set = store[rd_ptr];
endmodule

// File: rtl/sset_ptrs.sv
module sset_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_snap,
  input  logic             arm,
  input  logic             wr_valid,
  input  logic             rd_adv,
  output logic             clr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty,
  output logic             snap_done
);
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] cap_cnt;
  logic             capturing;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  assign clr   = mode_snap && arm;
  assign full  = (int'(count) == DEPTH);
  assign empty = (count == '0);
  assign wr_en = wr_valid && !full && !clr && (!mode_snap || capturing);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      cap_cnt <= '0; capturing <= 1'b0; snap_done <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      cap_cnt <= '0; capturing <= 1'b1; snap_done <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_adv) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_adv})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (mode_snap && capturing && wr_en) begin
        if (int'(cap_cnt) == DEPTH-1) begin
          capturing <= 1'b0;
          snap_done <= 1'b1;
        end else begin
          cap_cnt <= cap_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sset_rdport.sv
module sset_rdport
  import sset_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               empty,
  input  logic [SET_W-1:0]   rd_set,
  input  logic               w_req,
  input  logic [SEL_W-1:0]   w_sel,
  input  logic               b_req,
  output logic               w_grant,
  output logic               b_grant,
  output logic               rd_adv,
  output logic               w_ack,
  output logic [FIELD_W-1:0] w_data,
  output logic               b_ack,
  output logic [7:0]         b_data
);
  logic [CUR_W-1:0] cur;
  logic             b_last;

  assign w_grant = w_req && !empty && !clr;
  assign b_grant = b_req && !w_req && !empty && !clr;
  assign b_last  = (int'(cur) == BYTES_SET-1);
  assign rd_adv  = (w_grant && w_sel == SEL_FRQ) || (b_grant && b_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; w_ack <= 1'b0; b_ack <= 1'b0;
      w_data <= '0; b_data <= '0;
    end else begin
      w_ack <= w_grant;
      b_ack <= b_grant;
      if (w_grant) w_data <= pick_field(rd_set, w_sel);
      if (b_grant) b_data <= pick_byte(rd_set, cur);
      if (clr)          cur <= '0;
      else if (b_grant) cur <= b_last ? '0 : cur + 1'b1;
    end
  end
endmodule

// File: rtl/sset_buffer.sv
module sset_buffer
  import sset_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_snap,
  input  logic         arm,
  input  logic         wr_valid,
  input  logic [15:0]  wr_i,
  input  logic [15:0]  wr_q,
  input  logic [15:0]  wr_mag,
  input  logic [15:0]  wr_phase,
  input  logic [15:0]  wr_freq,
  input  logic         w_req,
  input  logic [2:0]   w_sel,
  output logic         w_ack,
  output logic [15:0]  w_data,
  input  logic         b_req,
  output logic         b_ack,
  output logic [7:0]   b_data,
  output logic         full,
  output logic         empty,
  output logic         snap_done
);
  logic             clr, wr_en, rd_adv, w_grant, b_grant;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [SET_W-1:0] wr_set, rd_set;

  assign wr_set = {wr_freq, wr_phase, wr_mag, wr_q, wr_i};

  sset_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk, .rst_n, .mode_snap, .arm, .wr_valid, .rd_adv,
    .clr, .wr_en, .wr_ptr, .rd_ptr, .full, .empty, .snap_done
  );

  sset_mem #(.DEPTH(DEPTH)) u_mem (
    .clk, .wr_en, .wr_ptr, .wr_set, .rd_ptr, .rd_set
  );

  sset_rdport u_rd (
    .clk, .rst_n, .clr, .empty, .rd_set, .w_req, .w_sel, .b_req,
    .w_grant, .b_grant, .rd_adv, .w_ack, .w_data, .b_ack, .b_data
  );
endmodule

// File: rtl/sset_checker.sv
module sset_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_snap,
  input logic wr_en,
  input logic w_req,
  input logic b_req,
  input logic w_ack,
  input logic b_ack,
  input logic w_grant,
  input logic b_grant,
  input logic full,
  input logic empty,
  input logic snap_done
);
  a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);
  a_r2_empty_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && w_req) |=> !w_ack);
  a_r9_word_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (w_req && b_req) |=> !b_ack);
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_grant && b_grant));
  a_r8_done_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_done && mode_snap) |-> !wr_en);
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind sset_buffer sset_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_snap(mode_snap), .wr_en(wr_en),
  .w_req(w_req), .b_req(b_req), .w_ack(w_ack), .b_ack(b_ack),
  .w_grant(w_grant), .b_grant(b_grant), .full(full), .empty(empty),
  .snap_done(snap_done)
);

// File: tb/sset_buffer_bench.sv
module sset_buffer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, mode_snap = 1'b0, arm = 1'b0, wr_valid = 1'b0;
  logic [15:0] wr_i = '0, wr_q = '0, wr_mag = '0, wr_phase = '0, wr_freq = '0;
  logic w_req = 1'b0, b_req = 1'b0;
  logic [2:0] w_sel = '0;
  logic w_ack, b_ack, full, empty, snap_done;
  logic [15:0] w_data;
  logic [7:0] b_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sset_buffer u_sset_buffer (.*);

  function automatic logic [15:0] fval(input int s, input int k);
    return 16'((s * 16'h0123) ^ (k * 16'h1C07) ^ 16'hA5A5);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic put_set(input int s);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_i = fval(s,0); wr_q = fval(s,1); wr_mag = fval(s,2);
    wr_phase = fval(s,3); wr_freq = fval(s,4);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic word_rd(input logic [2:0] sel, output logic ack, output logic [15:0] d);
    @(negedge clk);
    w_req = 1'b1; w_sel = sel;
    @(negedge clk);
    w_req = 1'b0;
    ack = w_ack; d = w_data;
  endtask

  task automatic byte_rd(output logic ack, output logic [7:0] d);
    @(negedge clk);
    b_req = 1'b1;
    @(negedge clk);
    b_req = 1'b0;
    ack = b_ack; d = b_data;
  endtask

  task automatic word_set(input string req, input int s);
    logic a; logic [15:0] d;
    for (int k = 0; k < 5; k++) begin
      word_rd(3'(k), a, d);
      chk(req, {15'd0, a}, 32'd1);
      chk(req, {16'd0, d}, {16'd0, fval(s,k)});
    end
  endtask

  task automatic byte_set(input string req, input int s, input int first);
    logic a; logic [7:0] d; logic [15:0] f;
    for (int c = first; c < 10; c++) begin
      byte_rd(a, d);
      f = fval(s, c/2);
      chk(req, {31'd0, a}, 32'd1);
      chk(req, {24'd0, d}, {24'd0, (c % 2) ? f[15:8] : f[7:0]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a; logic [15:0] d; logic [7:0] bd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", {31'd0, empty}, 1); chk("R1 full", {31'd0, full}, 0);
    chk("R1 done", {31'd0, snap_done}, 0);
    chk("R1 acks", {30'd0, w_ack, b_ack}, 0);
    rst_n = 1'b1;
    // R2 request while empty
    word_rd(3'd0, a, d); chk("R2 no ack empty", {31'd0, a}, 0);
    byte_rd(a, bd);      chk("R2 no byte ack empty", {31'd0, a}, 0);
    // R4 fill queue
    for (int s = 0; s < 8; s++) begin
      put_set(s);
      chk("R4 full flag", {31'd0, full}, (s == 7) ? 1 : 0);
    end
    // R5 dropped while full
    put_set(99); chk("R5 still full", {31'd0, full}, 1);
    // R3 field codes 5..7 read zero and do not advance
    for (int k = 5; k < 8; k++) begin
      word_rd(3'(k), a, d);
      chk("R3 bad code ack", {31'd0, a}, 1); chk("R3 bad code zero", {16'd0, d}, 0);
    end
    word_set("R3 R4 set0 fields", 0);
    chk("R3 advance clears full", {31'd0, full}, 0);
    // R6 byte order for sets 1..7
    for (int s = 1; s < 8; s++) byte_set("R6 byte order", s, 0);
    chk("R4 R5 empty after eight", {31'd0, empty}, 1);
    // R4 wrap past slot 7
    for (int s = 10; s < 13; s++) put_set(s);
    for (int s = 10; s < 13; s++) word_set("R4 wrap order", s);
    chk("R4 empty after wrap", {31'd0, empty}, 1);
    // R9 simultaneous requests
    put_set(20);
    @(negedge clk); w_req = 1'b1; w_sel = 3'd1; b_req = 1'b1;
    @(negedge clk); w_req = 1'b0;
    chk("R9 word served", {31'd0, w_ack}, 1);
    chk("R9 word data", {16'd0, w_data}, {16'd0, fval(20,1)});
    chk("R9 byte stalled", {31'd0, b_ack}, 0);
    @(negedge clk); b_req = 1'b0;
    chk("R9 byte served next", {31'd0, b_ack}, 1);
    chk("R9 byte position kept", {24'd0, b_data}, {24'd0, fval(20,0) & 16'hFF});
    byte_set("R9 R6 rest of set", 20, 1);
    chk("R6 advance after last byte", {31'd0, empty}, 1);
    // R7 capture mode
    mode_snap = 1'b1;
    put_set(40); chk("R7 ignored before arm", {31'd0, empty}, 1);
    @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
    chk("R8 done cleared by arm", {31'd0, snap_done}, 0);
    for (int s = 30; s < 40; s++) begin
      put_set(s);
      if (s == 36) chk("R8 not done at seven", {31'd0, snap_done}, 0);
    end
    chk("R8 done after eight", {31'd0, snap_done}, 1);
    chk("R7 eight held", {31'd0, full}, 1);
    for (int s = 30; s < 38; s++) word_set("R7 captured order", s);
    chk("R7 extra sets ignored", {31'd0, empty}, 1);
    put_set(50); chk("R7 frozen after done", {31'd0, empty}, 1);
    chk("R8 done holds", {31'd0, snap_done}, 1);
    @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
    chk("R8 rearm clears done", {31'd0, snap_done}, 0);
    put_set(60); word_set("R7 capture after rearm", 60);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule